// File: doc/BRIEF.md
# Preserved Program Order Checker

This block decides, for two memory operations issued by the same hardware thread, whether the older one must become globally visible before the younger one. It looks at the kind of each operation, its address and its acquire/release annotation, at the fences that lie between the two in program order, and at the dependence links from the older operation to the younger one. It returns one must-order verdict and a code naming the strongest rule that produced it.

The checker is purely combinational. A memory pipeline or a reorder queue asks it about one candidate pair at a time. A store-to-load or load-to-load reordering may go ahead only when `must_order` is low. The block also flags fence encodings outside the legal set, and annotations it had to strengthen, so that the surrounding logic can report them.

Top module: `ppo_order_check`

## Requirements
- R1: Kind codes are 0 plain load, 1 load-reserve, 2 plain store, 3 store-conditional and 4 atomic. Loads are kinds 0, 1 and 4, and stores are kinds 2, 3 and 4. Codes 5 to 7 are not memory operations, and a pair that contains one is never ordered.
- R2: Each fence slot carries four bits: bit 3 predecessor-read, bit 2 predecessor-write, bit 1 successor-read and bit 0 successor-write. A valid legal slot orders the pair when the predecessor bit matching the older operation's class and the successor bit matching the younger operation's class are both set.
- R3: A valid slot with its TSO flag set ignores its four bits. It orders an older load before any younger memory operation, and an older store before a younger store only.
- R4: The legal bit sets of a non-TSO slot are 1010, 0101, 1101, 1011 and 1111. Any other set in a valid slot raises `fence_illegal`, and that slot gives no ordering.
- R5: An older operation with an effective acquire annotation is ordered before any younger memory operation.
- R6: A younger operation with an effective release annotation is ordered after any older memory operation.
- R7: When both operations carry an annotation and both have the RCsc flag set, the pair is ordered.
- R8: A load (kinds 0, 1, 4) marked release is also treated as acquire, and a store (kinds 2, 3, 4) marked acquire is also treated as release. `annot_promoted` goes high whenever either operation was strengthened in this way.
- R9: A younger store to the same address as an older memory operation is ordered.
- R10: An address or data dependence orders the pair. A control dependence orders the pair only when the younger operation is a store.
- R11: Dependence flags are ignored when the older operation is a plain store (kind 2).
- R12: When `rsv_pair` is high, an older load-reserve and a younger store-conditional are ordered.
- R13: `order_reason` gives the first rule that applies, in this order: 1 same address, 2 reservation pair, 3 annotation, 4 fence, 5 dependence. It is 0 exactly when `must_order` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| old_kind | input | 3 | Kind code of the older operation |
| old_addr | input | ADDR_W | Address of the older operation |
| old_aq | input | 1 | Older operation marked acquire |
| old_rl | input | 1 | Older operation marked release |
| old_rcsc | input | 1 | Older annotation is RCsc flavour |
| new_kind | input | 3 | Kind code of the younger operation |
| new_addr | input | ADDR_W | Address of the younger operation |
| new_aq | input | 1 | Younger operation marked acquire |
| new_rl | input | 1 | Younger operation marked release |
| new_rcsc | input | 1 | Younger annotation is RCsc flavour |
| fence_valid | input | NUM_FENCES | Fence slot holds an intervening fence |
| fence_tso | input | NUM_FENCES | Fence slot is the TSO variant |
| fence_bits | input | 4*NUM_FENCES | Four ordering bits per slot, slot i at [4i+3:4i] |
| rsv_pair | input | 1 | Older load-reserve is paired with the younger store-conditional |
| dep_addr | input | 1 | Address dependence from older to younger |
| dep_data | input | 1 | Data dependence from older to younger |
| dep_ctrl | input | 1 | Control dependence from older to younger |
| must_order | output | 1 | Pair must keep program order |
| order_reason | output | 3 | Priority-encoded reason, 0 when unordered |
| fence_illegal | output | 1 | A valid non-TSO slot holds an illegal bit set |
| annot_promoted | output | 1 | An annotation was strengthened |

## Verification
Directed pairs pull each rule apart from the others. Store-to-load pairs behind 1010, 0101 and 1111 fences show whether the right predecessor and successor bits are chosen. TSO fences on store-load and load-load pairs show its one asymmetry. Pairs where only one side is RCsc, and control dependences to a load, show that those conditions alone give no ordering. A plain-store source with dependence flags shows that they are ignored. Overlapping cases, such as a paired reservation at the same address, check the priority of the reason code. A long run of random pairs over a small address pool then mixes kinds, annotations, fences and dependences, and the outputs are compared against a bench model.

// File: rtl/ppo_pkg.sv
package ppo_pkg;

  localparam logic [2:0] KIND_LD     = 3'd0;
  localparam logic [2:0] KIND_LR     = 3'd1;
  localparam logic [2:0] KIND_ST     = 3'd2;
  localparam logic [2:0] KIND_SC     = 3'd3;
  localparam logic [2:0] KIND_AMO    = 3'd4;

  localparam logic [2:0] WHY_NONE    = 3'd0;
  localparam logic [2:0] WHY_ADDR    = 3'd1;
  localparam logic [2:0] WHY_PAIR    = 3'd2;
  localparam logic [2:0] WHY_ANNOT   = 3'd3;
  localparam logic [2:0] WHY_FENCE   = 3'd4;
  localparam logic [2:0] WHY_DEP     = 3'd5;

  // fence bit positions inside one slot
  localparam int FB_PR = 3;
  localparam int FB_PW = 2;
  localparam int FB_SR = 1;
  localparam int FB_SW = 0;

  typedef struct packed {
    logic is_mem;
    logic is_load;
    logic is_store;
    logic is_plain_st;
    logic is_lr;
    logic is_sc;
    logic acq;
    logic rel;
    logic rcsc_tag;
    logic promoted;
  } op_attr_t;

endpackage

// File: rtl/ppo_op_decode.sv
module ppo_op_decode
  import ppo_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       aq,
  input  logic       rl,
  input  logic       rcsc,
  output op_attr_t   attr
);

  logic ld, st;

  always_comb begin
    ld = (kind == KIND_LD) || (kind == KIND_LR) || (kind == KIND_AMO);
    st = (kind == KIND_ST) || (kind == KIND_SC) || (kind == KIND_AMO);
    attr.is_load     = ld;
    attr.is_store    = st;
    attr.is_mem      = ld | st;
    attr.is_plain_st = (kind == KIND_ST);
    attr.is_lr       = (kind == KIND_LR);
    attr.is_sc       = (kind == KIND_SC);
    // release on a load implies acquire; acquire on a store implies release
    attr.acq         = (ld | st) & (aq | (rl & ld));
    attr.rel         = (ld | st) & (rl | (aq & st));
    attr.promoted    = (attr.acq & ~aq) | (attr.rel & ~rl);
    attr.rcsc_tag    = rcsc & (attr.acq | attr.rel);
  end

endmodule

// File: rtl/ppo_fence_eval.sv
module ppo_fence_eval
  import ppo_pkg::*;
#(
  parameter int NUM_FENCES = 4
) (
  input  logic [NUM_FENCES-1:0]   valid,
  input  logic [NUM_FENCES-1:0]   tso,
  input  logic [4*NUM_FENCES-1:0] bits,
  input  logic                    o_ld,
  input  logic                    o_st,
  input  logic                    y_ld,
  input  logic                    y_st,
  output logic                    ordered,
  output logic                    illegal
);

  logic [NUM_FENCES-1:0] slot_ord;
  logic [NUM_FENCES-1:0] slot_bad;

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_slot
    logic [3:0] b;
    logic       legal_set;
    logic       pair_hit;
    logic       tso_hit;

    always_comb begin
      b         = bits[4*g +: 4];
      legal_set = (b == 4'b1010) || (b == 4'b0101) || (b == 4'b1101) ||
                  (b == 4'b1011) || (b == 4'b1111);
      pair_hit  = (o_ld & y_ld & b[FB_PR] & b[FB_SR]) |
                  (o_ld & y_st & b[FB_PR] & b[FB_SW]) |
                  (o_st & y_ld & b[FB_PW] & b[FB_SR]) |
                  (o_st & y_st & b[FB_PW] & b[FB_SW]);
      tso_hit   = (o_ld & (y_ld | y_st)) | (o_st & y_st);
      slot_bad[g] = valid[g] & ~tso[g] & ~legal_set;
      slot_ord[g] = valid[g] & (tso[g] ? tso_hit : (legal_set & pair_hit));
    end
  end

  assign ordered = |slot_ord;
  assign illegal = |slot_bad;

endmodule

// File: rtl/ppo_order_check.sv
module ppo_order_check
  import ppo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_FENCES = 4
) (
  input  logic [2:0]              old_kind,
  input  logic [ADDR_W-1:0]       old_addr,
  input  logic                    old_aq,
  input  logic                    old_rl,
  input  logic                    old_rcsc,
  input  logic [2:0]              new_kind,
  input  logic [ADDR_W-1:0]       new_addr,
  input  logic                    new_aq,
  input  logic                    new_rl,
  input  logic                    new_rcsc,
  input  logic [NUM_FENCES-1:0]   fence_valid,
  input  logic [NUM_FENCES-1:0]   fence_tso,
  input  logic [4*NUM_FENCES-1:0] fence_bits,
  input  logic                    rsv_pair,
  input  logic                    dep_addr,
  input  logic                    dep_data,
  input  logic                    dep_ctrl,
  output logic                    must_order,
  output logic [2:0]              order_reason,
  output logic                    fence_illegal,
  output logic                    annot_promoted
);

  op_attr_t oa, ya;
  logic     fence_hit;
  logic     both_mem;
  logic     hit_addr, hit_pair, hit_annot, hit_fence, hit_dep;

  ppo_op_decode u_old (
    .kind (old_kind), .aq (old_aq), .rl (old_rl), .rcsc (old_rcsc), .attr (oa)
  );

  ppo_op_decode u_new (
    .kind (new_kind), .aq (new_aq), .rl (new_rl), .rcsc (new_rcsc), .attr (ya)
  );

  ppo_fence_eval #(.NUM_FENCES(NUM_FENCES)) u_fence (
    .valid   (fence_valid),
    .tso     (fence_tso),
    .bits    (fence_bits),
    .o_ld    (oa.is_load),
    .o_st    (oa.is_store),
    .y_ld    (ya.is_load),
    .y_st    (ya.is_store),
    .ordered (fence_hit),
    .illegal (fence_illegal)
  );

  always_comb begin
    both_mem  = oa.is_mem & ya.is_mem;
    hit_addr  = both_mem & ya.is_store & (old_addr == new_addr);
    hit_pair  = rsv_pair & oa.is_lr & ya.is_sc;
    hit_annot = both_mem & (oa.acq | ya.rel | (oa.rcsc_tag & ya.rcsc_tag));
    hit_fence = both_mem & fence_hit;
    hit_dep   = both_mem & ~oa.is_plain_st &
                (dep_addr | dep_data | (dep_ctrl & ya.is_store));

    if (hit_addr)       order_reason = WHY_ADDR;
    else if (hit_pair)  order_reason = WHY_PAIR;
    else if (hit_annot) order_reason = WHY_ANNOT;
    else if (hit_fence) order_reason = WHY_FENCE;
    else if (hit_dep)   order_reason = WHY_DEP;
    else                order_reason = WHY_NONE;
  end

  assign must_order     = hit_addr | hit_pair | hit_annot | hit_fence | hit_dep;
  assign annot_promoted = oa.promoted | ya.promoted;

endmodule

// File: rtl/ppo_order_check_sva.sv
module ppo_order_check_sva #(
  parameter int ADDR_W     = 32,
  parameter int NUM_FENCES = 4
) (
  input logic [2:0]            old_kind,
  input logic [ADDR_W-1:0]     old_addr,
  input logic                  old_aq,
  input logic                  old_rl,
  input logic [2:0]            new_kind,
  input logic [ADDR_W-1:0]     new_addr,
  input logic                  new_aq,
  input logic                  new_rl,
  input logic [NUM_FENCES-1:0] fence_valid,
  input logic [NUM_FENCES-1:0] fence_tso,
  input logic                  must_order,
  input logic [2:0]            order_reason,
  input logic                  fence_illegal,
  input logic                  annot_promoted
);

  logic old_mem, new_mem, new_st;

  always_comb begin
    old_mem = (old_kind <= 3'd4);
    new_mem = (new_kind <= 3'd4);
    new_st  = (new_kind == 3'd2) || (new_kind == 3'd3) || (new_kind == 3'd4);

    a_r13_zero_iff_free: assert ((order_reason == 3'd0) == !must_order);
    a_r13_code_range:    assert (order_reason <= 3'd5);
    if (!old_mem || !new_mem)
      a_r1_nonmem_free:  assert (!must_order);
    if (old_mem && new_st && old_addr == new_addr)
      a_r9_same_addr:    assert (order_reason == 3'd1);
    if (old_mem && new_mem && old_aq)
      a_r5_acquire:      assert (must_order);
    if (old_mem && new_mem && new_rl)
      a_r6_release:      assert (must_order);
    if (fence_illegal)
      a_r4_needs_slot:   assert ((fence_valid & ~fence_tso) != '0);
    if (annot_promoted)
      a_r8_needs_mark:   assert (old_aq | old_rl | new_aq | new_rl);
  end

endmodule

bind ppo_order_check ppo_order_check_sva #(
  .ADDR_W(ADDR_W), .NUM_FENCES(NUM_FENCES)
) u_sva (
  .old_kind       (old_kind),
  .old_addr       (old_addr),
  .old_aq         (old_aq),
  .old_rl         (old_rl),
  .new_kind       (new_kind),
  .new_addr       (new_addr),
  .new_aq         (new_aq),
  .new_rl         (new_rl),
  .fence_valid    (fence_valid),
  .fence_tso      (fence_tso),
  .must_order     (must_order),
  .order_reason   (order_reason),
  .fence_illegal  (fence_illegal),
  .annot_promoted (annot_promoted)
);

// File: tb/ppo_order_check_test.sv
module ppo_order_check_test;

  localparam int AW = 32;
  localparam int NF = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [2:0]    old_kind, new_kind;
  logic [AW-1:0] old_addr, new_addr;
  logic          old_aq, old_rl, old_rcsc, new_aq, new_rl, new_rcsc;
  logic [NF-1:0] fence_valid, fence_tso;
  logic [4*NF-1:0] fence_bits;
  logic          rsv_pair, dep_addr, dep_data, dep_ctrl;
  logic          must_order, fence_illegal, annot_promoted;
  logic [2:0]    order_reason;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  ppo_order_check #(.ADDR_W(AW), .NUM_FENCES(NF)) uut (.*);

  function automatic bit is_ld(input logic [2:0] k);
    return k == 3'd0 || k == 3'd1 || k == 3'd4;
  endfunction
  function automatic bit is_st(input logic [2:0] k);
    return k == 3'd2 || k == 3'd3 || k == 3'd4;
  endfunction

  // expected {must, reason[2:0], illegal, promoted}
  function automatic logic [5:0] model();
    bit ol = is_ld(old_kind), os = is_st(old_kind);
    bit yl = is_ld(new_kind), ys = is_st(new_kind);
    bit mem = (ol | os) & (yl | ys);
    bit oacq = (ol|os) & (old_aq | (old_rl & ol));
    bit orel = (ol|os) & (old_rl | (old_aq & os));
    bit yacq = (yl|ys) & (new_aq | (new_rl & yl));
    bit yrel = (yl|ys) & (new_rl | (new_aq & ys));
    bit prom = (oacq & !old_aq) | (orel & !old_rl) | (yacq & !new_aq) | (yrel & !new_rl);
    bit fo = 0, bad = 0;
    logic [2:0] why;
    for (int i = 0; i < NF; i++) begin
      logic [3:0] b = fence_bits[4*i +: 4];
      bit ok = b inside {4'b1010, 4'b0101, 4'b1101, 4'b1011, 4'b1111};
      if (fence_valid[i]) begin
        if (fence_tso[i]) fo |= ol | (os & ys);
        else if (!ok) bad = 1;
        else fo |= (ol&yl&b[3]&b[1]) | (ol&ys&b[3]&b[0]) | (os&yl&b[2]&b[1]) | (os&ys&b[2]&b[0]);
      end
    end
    if (mem && ys && old_addr == new_addr) why = 3'd1;
    else if (rsv_pair && old_kind == 3'd1 && new_kind == 3'd3) why = 3'd2;
    else if (mem && (oacq || yrel || (old_rcsc && (oacq|orel) && new_rcsc && (yacq|yrel)))) why = 3'd3;
    else if (mem && fo) why = 3'd4;
    else if (mem && old_kind != 3'd2 && (dep_addr || dep_data || (dep_ctrl && ys))) why = 3'd5;
    else why = 3'd0;
    return {why != 0, why, bad, prom};
  endfunction

  task automatic clear();
    old_kind = 0; new_kind = 0; old_addr = 0; new_addr = 0;
    old_aq = 0; old_rl = 0; old_rcsc = 0; new_aq = 0; new_rl = 0; new_rcsc = 0;
    fence_valid = 0; fence_tso = 0; fence_bits = 0;
    rsv_pair = 0; dep_addr = 0; dep_data = 0; dep_ctrl = 0;
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] got;
    @(negedge clk);
    got = {must_order, order_reason, fence_illegal, annot_promoted};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got must=%0b why=%0d ill=%0b prom=%0b, expected must=%0b why=%0d ill=%0b prom=%0b",
               req, got[5], got[4:2], got[1], got[0], exp[5], exp[4:2], exp[1], exp[0]);
    end
    @(posedge clk);
  endtask

  initial begin
    clear();
    @(posedge clk);
    check("R13 idle load-load same address unordered", 6'b0_000_0_0);
    new_kind = 2;                              check("R9 load then store same address", 6'b1_001_0_0);
    old_kind = 2; new_kind = 0; new_addr = 4;
    fence_valid = 1; fence_bits = 16'h000A;    check("R2 store-load behind 1010 fence", 6'b0_000_0_0);
    fence_bits = 16'h0005;                     check("R2 store-load behind 0101 fence", 6'b0_000_0_0);
    fence_bits = 16'h00F0; fence_valid = 4'b0010; check("R2 store-load behind 1111 in slot 1", 6'b1_100_0_0);
    fence_bits = 0; fence_valid = 1; fence_tso = 1; check("R3 tso fence store-load", 6'b0_000_0_0);
    old_kind = 0;                              check("R3 tso fence load-load", 6'b1_100_0_0);
    fence_tso = 0; fence_bits = 16'h0008;      check("R4 illegal 1000 fence", 6'b0_000_1_0);
    fence_valid = 0;                           check("R4 invalid slot not flagged", 6'b0_000_0_0);
    old_aq = 1;                                check("R5 older acquire", 6'b1_011_0_0);
    old_aq = 0; new_rl = 1;                    check("R6 R8 younger load release", 6'b1_011_0_1);
    new_rl = 0; old_kind = 2; old_aq = 1;      check("R5 R8 store acquire promoted", 6'b1_011_0_1);
    old_aq = 0; old_rl = 1; old_rcsc = 1; new_aq = 1; new_rcsc = 1;
                                               check("R7 both RCsc store-rl then load-aq", 6'b1_011_0_0);
    new_rcsc = 0;                              check("R7 only one RCsc", 6'b0_000_0_0);
    clear(); new_addr = 8; dep_addr = 1;       check("R10 address dependence", 6'b1_101_0_0);
    dep_addr = 0; dep_ctrl = 1;                check("R10 control dependence to load", 6'b0_000_0_0);
    new_kind = 2;                              check("R10 control dependence to store", 6'b1_101_0_0);
    dep_ctrl = 0; old_kind = 2; new_kind = 0; dep_data = 1; dep_addr = 1; dep_ctrl = 1;
                                               check("R11 plain store dependences ignored", 6'b0_000_0_0);
    clear(); old_kind = 1; new_kind = 3; rsv_pair = 1; check("R12 R13 pair same address", 6'b1_001_0_0);
    new_addr = 16;                             check("R12 reservation pair", 6'b1_010_0_0);
    rsv_pair = 0;                              check("R12 unpaired", 6'b0_000_0_0);
    clear(); old_kind = 6; old_aq = 1; new_kind = 2; check("R1 non-memory kind", 6'b0_000_0_0);

    for (int n = 0; n < 4000; n++) begin
      old_kind = 3'($urandom % 6); new_kind = 3'($urandom % 6);
      old_addr = AW'($urandom % 3); new_addr = AW'($urandom % 3);
      {old_aq, old_rl, old_rcsc, new_aq, new_rl, new_rcsc} = 6'($urandom);
      if ($urandom % 2) {old_aq, old_rl, new_aq, new_rl} = 4'b0;
      fence_valid = NF'($urandom); fence_tso = NF'($urandom & $urandom);
      fence_bits = (4*NF)'($urandom);
      {rsv_pair, dep_addr, dep_data, dep_ctrl} = 4'($urandom & $urandom);
      check("R1-13 random mix", model());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    $urandom(32'h5eed_0042);
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got running, expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule